// File: doc/BRIEF.md
# Temporal Neighbor Sampler with Cross-Target Deduplication

This block samples the temporal neighbors of a small batch of target vertices without sampling any neighbor twice. Each target is given as a base address and an entry count into an on-chip table. Each table word holds one timestamped interaction as a triple of neighbor vertex, root vertex and timestamp. The block first orders the targets by their largest interaction timestamp, latest first. It then reads each target's entries through a one-cycle-latency read port and emits the surviving edges on a valid/ready stream.

A visited bitmap lives for the whole batch. A neighbor that has already been emitted is suppressed, whether it shows up again under the same root or under a later target. A target that was itself sampled earlier is therefore handled as a fresh root, and only its unvisited neighbors come out. A start pulse clears the bitmap and launches a batch. A one-cycle done pulse closes the batch. The target descriptors must stay stable from start until done.

Top module: `tnbr_sampler`

## Requirements
- R1: After reset, out_valid, done and tbl_rd are low until a start pulse arrives.
- R2: Targets are visited in descending order of their maximum timestamp. On a tie, the target with the lower slot index goes first.
- R3: Within one target, entries are read from base to base+len-1 in ascending address order. A read of address A on tbl_rd returns the word on tbl_data in the next cycle, packed as {neighbor[VW], root[VW], timestamp[TSW]} with the neighbor in the top bits. An emitted edge carries that entry's root, neighbor and timestamp.
- R4: Within one batch, a neighbor vertex is emitted at most once, across all targets. Any later entry naming it, including one under a target that re-enters as a root, produces nothing.
- R5: An entry whose neighbor equals its root is skipped, and its vertex is not marked visited. A later entry naming that vertex as a neighbor is still emitted.
- R6: A start pulse clears the visited bitmap, so a repeated batch emits the same stream again.
- R7: While out_valid is high and out_ready is low, the edge fields stay stable and no table read is issued.
- R8: After the last entry of the last target has been handled, done is high for exactly one cycle. Every edge of the batch has been accepted before done, and out_valid is low while done is high.
- R9: A start pulse that arrives while a batch is running is ignored.
- R10: A target with zero entries emits nothing. A batch with tgt_count of zero raises done without emitting or reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear visited state and begin a batch |
| tgt_count | input | CW | Number of valid target slots (0..NT) |
| tgt_base | input | NT*AW | Slot i base address at bits [i*AW +: AW] |
| tgt_len | input | NT*LW | Slot i entry count at bits [i*LW +: LW] |
| tgt_maxts | input | NT*TSW | Slot i maximum timestamp at bits [i*TSW +: TSW] |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | AW | Table read address |
| tbl_data | input | DW | Table word, one cycle after the read |
| out_valid | output | 1 | Sampled edge valid |
| out_ready | input | 1 | Consumer ready |
| out_root | output | VW | Root vertex of the edge |
| out_nbr | output | VW | Neighbor vertex of the edge |
| out_ts | output | TSW | Edge timestamp |
| done | output | 1 | One-cycle batch completion pulse |

## Verification
The delicate overlap is between the final handshake of a batch and batch completion. The last edge can be held by backpressure in the same cycle that the address walk finds its last target exhausted. Done must then wait until that edge is accepted, and must never coincide with a valid edge. The bench drives out_ready randomly over batches whose final entries are emitted, skipped or empty. It checks that the whole expected stream has been received by the cycle in which done appears, and that done appears exactly once. A second overlap, a start pulse landing mid-batch, is provoked during the sorting phase and judged by the stream staying identical to the reference.

// File: rtl/tnbr_pkg.sv
package tnbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SORT, ST_LOAD, ST_ISSUE, ST_EVAL, ST_HOLD, ST_DONE
  } tnbr_state_e;
endpackage

// File: rtl/tnbr_sort.sv
// Serial selection sort: for each output rank, scan all slots one per cycle
// and keep the largest unpicked maximum timestamp (strict compare, so the
// lower slot wins ties).
module tnbr_sort #(
  parameter int NT  = 8,
  parameter int TSW = 16,
  parameter int CW  = 4,
  parameter int IW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     count,
  input  logic [NT*TSW-1:0] maxts,
  output logic [NT*IW-1:0]  order,
  output logic              done
);
  logic           busy;
  logic [CW-1:0]  rank;
  logic [IW-1:0]  scan;
  logic [IW-1:0]  best_idx;
  logic [TSW-1:0] best_ts;
  logic           best_ok;
  logic [NT-1:0]  picked;
  logic [TSW-1:0] cur_ts;
  logic           take;
  logic [IW-1:0]  win;

  always_comb begin
    cur_ts = maxts[scan*TSW +: TSW];
    take   = busy && (CW'(scan) < count) && !picked[scan] &&
             (!best_ok || cur_ts > best_ts);
    win    = take ? scan : best_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rank     <= '0;
      scan     <= '0;
      best_idx <= '0;
      best_ts  <= '0;
      best_ok  <= 1'b0;
      picked   <= '0;
      order    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        rank    <= '0;
        scan    <= '0;
        best_ok <= 1'b0;
        picked  <= '0;
      end else if (busy) begin
        if (take) begin
          best_idx <= scan;
          best_ts  <= cur_ts;
          best_ok  <= 1'b1;
        end
        if (scan == IW'(NT-1)) begin
          order[rank*IW +: IW] <= win;
          picked[win]          <= 1'b1;
          best_ok              <= 1'b0;
          scan                 <= '0;
          if (rank == count - CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            rank <= rank + CW'(1);
          end
        end else begin
          scan <= scan + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tnbr_agen.sv
// Address generator: registered read address plus remaining-entry counter.
module tnbr_agen #(
  parameter int AW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          empty
);
  logic [LW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= len;
    end else if (step) begin
      addr   <= addr + AW'(1);
      remain <= remain - LW'(1);
    end
  end

  assign empty = (remain == '0);
endmodule

// File: rtl/tnbr_visit.sv
// Batch-wide visited bitmap, one flag per vertex id.
module tnbr_visit #(
  parameter int VW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [VW-1:0] set_idx,
  input  logic [VW-1:0] look_idx,
  output logic          hit
);
  localparam int NV = 1 << VW;
  logic [NV-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst || clr) seen <= '0;
    else if (set)   seen[set_idx] <= 1'b1;
  end

  assign hit = seen[look_idx];
endmodule

// File: rtl/tnbr_sampler.sv
module tnbr_sampler
  import tnbr_pkg::*;
#(
  parameter int NT  = 8,
  parameter int VW  = 5,
  parameter int TSW = 16,
  parameter int AW  = 6,
  localparam int LW = AW + 1,
  localparam int CW = $clog2(NT + 1),
  localparam int IW = $clog2(NT),
  localparam int DW = 2 * VW + TSW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     tgt_count,
  input  logic [NT*AW-1:0]  tgt_base,
  input  logic [NT*LW-1:0]  tgt_len,
  input  logic [NT*TSW-1:0] tgt_maxts,
  output logic              tbl_rd,
  output logic [AW-1:0]     tbl_addr,
  input  logic [DW-1:0]     tbl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     out_root,
  output logic [VW-1:0]     out_nbr,
  output logic [TSW-1:0]    out_ts,
  output logic              done
);
  tnbr_state_e    state;
  logic [CW-1:0]  tpos;
  logic [NT*IW-1:0] order_flat;
  logic           sort_start, sort_done;
  logic [IW-1:0]  cur_idx;
  logic [AW-1:0]  sel_base;
  logic [LW-1:0]  sel_len;
  logic           ag_load, ag_step, ag_empty;
  logic [AW-1:0]  ag_addr;
  logic           vis_clr, vis_hit, emit;
  logic [VW-1:0]  ent_nbr, ent_root;
  logic [TSW-1:0] ent_ts;
  logic           last_tgt;

  assign ent_nbr  = tbl_data[DW-1 -: VW];
  assign ent_root = tbl_data[TSW+VW-1 -: VW];
  assign ent_ts   = tbl_data[TSW-1:0];

  always_comb begin
    cur_idx    = order_flat[tpos*IW +: IW];
    sel_base   = tgt_base[cur_idx*AW +: AW];
    sel_len    = tgt_len[cur_idx*LW +: LW];
    sort_start = (state == ST_IDLE) && start && (tgt_count != '0);
    vis_clr    = (state == ST_IDLE) && start;
    ag_load    = (state == ST_LOAD);
    tbl_rd     = (state == ST_ISSUE) && !ag_empty;
    ag_step    = tbl_rd;
    emit       = (state == ST_EVAL) && (ent_nbr != ent_root) && !vis_hit;
    last_tgt   = (tpos == tgt_count - CW'(1));
  end

  assign tbl_addr = ag_addr;
  assign done     = (state == ST_DONE);

  tnbr_sort #(.NT(NT), .TSW(TSW), .CW(CW), .IW(IW)) u_sort (
    .clk(clk), .rst(rst), .start(sort_start), .count(tgt_count),
    .maxts(tgt_maxts), .order(order_flat), .done(sort_done)
  );

  tnbr_agen #(.AW(AW), .LW(LW)) u_agen (
    .clk(clk), .rst(rst), .load(ag_load), .base(sel_base), .len(sel_len),
    .step(ag_step), .addr(ag_addr), .empty(ag_empty)
  );

  tnbr_visit #(.VW(VW)) u_visit (
    .clk(clk), .rst(rst), .clr(vis_clr), .set(emit), .set_idx(ent_nbr),
    .look_idx(ent_nbr), .hit(vis_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tpos      <= '0;
      out_valid <= 1'b0;
      out_root  <= '0;
      out_nbr   <= '0;
      out_ts    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= (tgt_count == '0) ? ST_DONE : ST_SORT;
        ST_SORT: if (sort_done) begin
          tpos  <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: state <= ST_ISSUE;
        ST_ISSUE: begin
          if (!ag_empty) state <= ST_EVAL;
          else if (last_tgt) state <= ST_DONE;
          else begin
            tpos  <= tpos + CW'(1);
            state <= ST_LOAD;
          end
        end
        ST_EVAL: begin
          if (emit) begin
            out_root  <= ent_root;
            out_nbr   <= ent_nbr;
            out_ts    <= ent_ts;
            out_valid <= 1'b1;
            state     <= ST_HOLD;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_ISSUE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tnbr_sampler_chk.sv
module tnbr_sampler_chk #(
  parameter int VW  = 5,
  parameter int TSW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           tbl_rd,
  input logic           out_valid,
  input logic           out_ready,
  input logic [VW-1:0]  out_root,
  input logic [VW-1:0]  out_nbr,
  input logic [TSW-1:0] out_ts,
  input logic           done
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !done && !tbl_rd)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_root) &&
    $stable(out_nbr) && $stable(out_ts))); // R7

  AST_NO_READ_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !tbl_rd); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !tbl_rd)); // R8

  AST_NO_SELF_EDGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_nbr != out_root)); // R5
endmodule

bind tnbr_sampler tnbr_sampler_chk #(.VW(VW), .TSW(TSW)) u_chk (
  .clk(clk), .rst(rst), .tbl_rd(tbl_rd), .out_valid(out_valid),
  .out_ready(out_ready), .out_root(out_root), .out_nbr(out_nbr),
  .out_ts(out_ts), .done(done)
);

// File: tb/tnbr_sampler_test.sv
module tnbr_sampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT  = 8;
  localparam int VW  = 5;
  localparam int TSW = 16;
  localparam int AW  = 6;
  localparam int LW  = AW + 1;
  localparam int CW  = $clog2(NT + 1);
  localparam int DW  = 2 * VW + TSW;
  localparam int NV  = 1 << VW;
  localparam int TBL = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] tgt_count = '0;
  logic [NT*AW-1:0] tgt_base = '0;
  logic [NT*LW-1:0] tgt_len = '0;
  logic [NT*TSW-1:0] tgt_maxts = '0;
  logic tbl_rd;
  logic [AW-1:0] tbl_addr;
  logic [DW-1:0] tbl_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [VW-1:0] out_root, out_nbr;
  logic [TSW-1:0] out_ts;
  logic done;

  tnbr_sampler #(.NT(NT), .VW(VW), .TSW(TSW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .tgt_count(tgt_count),
    .tgt_base(tgt_base), .tgt_len(tgt_len), .tgt_maxts(tgt_maxts),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_root(out_root),
    .out_nbr(out_nbr), .out_ts(out_ts), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [VW-1:0]  m_nbr [TBL];
  logic [VW-1:0]  m_root[TBL];
  logic [TSW-1:0] m_ts  [TBL];
  always @(posedge clk) if (tbl_rd) tbl_data <= {m_nbr[tbl_addr], m_root[tbl_addr], m_ts[tbl_addr]};

  int b_base[NT], b_len[NT], b_mts[NT], b_cnt;
  logic [VW-1:0]  e_root[TBL], e_nbr[TBL];
  logic [TSW-1:0] e_ts[TBL];
  int exp_n, got_n, done_cnt, ready_mode;
  int checks = 0, fails = 0, cyc = 0;
  bit hold_pend = 0;
  logic [VW-1:0] h_root, h_nbr;
  logic [TSW-1:0] h_ts;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic pack();
    tgt_count = CW'(b_cnt);
    for (int t = 0; t < NT; t++) begin
      tgt_base[t*AW +: AW]   = AW'(b_base[t]);
      tgt_len[t*LW +: LW]    = LW'(b_len[t]);
      tgt_maxts[t*TSW +: TSW] = TSW'(b_mts[t]);
    end
  endtask

  // Reference: order by max timestamp (latest first, lower slot on tie),
  // then emit unvisited non-self neighbors.
  task automatic build_expected();
    bit vis[NV];
    bit picked[NT];
    exp_n = 0;
    for (int v = 0; v < NV; v++) vis[v] = 0;
    for (int t = 0; t < NT; t++) picked[t] = 0;
    for (int k = 0; k < b_cnt; k++) begin
      int best = -1;
      for (int i = 0; i < b_cnt; i++)
        if (!picked[i] && (best < 0 || b_mts[i] > b_mts[best])) best = i;
      picked[best] = 1;
      for (int e = 0; e < b_len[best]; e++) begin
        int a = b_base[best] + e;
        if (m_nbr[a] != m_root[a] && !vis[m_nbr[a]]) begin
          vis[m_nbr[a]] = 1;
          e_root[exp_n] = m_root[a];
          e_nbr[exp_n] = m_nbr[a];
          e_ts[exp_n] = m_ts[a];
          exp_n++;
        end
      end
    end
  endtask

  // Monitor and consumer: outputs sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        chk(out_valid && out_root == h_root && out_nbr == h_nbr && out_ts == h_ts,
            "R7", "held edge changed", int'(out_nbr), int'(h_nbr));
        hold_pend = 0;
      end
      out_ready = (ready_mode == 0) ? 1'b1 : ($urandom % 2 == 0);
      if (out_valid && out_ready) begin
        if (got_n < exp_n) begin
          chk(out_root == e_root[got_n], "R2 R3 R4 R5", "root", int'(out_root), int'(e_root[got_n]));
          chk(out_nbr == e_nbr[got_n], "R2 R3 R4 R5", "neighbor", int'(out_nbr), int'(e_nbr[got_n]));
          chk(out_ts == e_ts[got_n], "R3", "timestamp", int'(out_ts), int'(e_ts[got_n]));
        end else begin
          chk(0, "R4", "extra edge index", got_n, exp_n);
        end
        got_n++;
      end else if (out_valid) begin
        hold_pend = 1;
        h_root = out_root; h_nbr = out_nbr; h_ts = out_ts;
      end
      if (done) begin
        done_cnt++;
        chk(got_n == exp_n, "R8", "edges accepted before done", got_n, exp_n);
        chk(!out_valid, "R8", "valid during done", int'(out_valid), 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_batch(string tag, bit poke);
    int w = 0;
    pack();
    build_expected();
    got_n = 0; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (done_cnt == 0 && w < 4000) begin
      @(negedge clk);
      w++;
      if (poke && w == 4) start = 1'b1;   // R9: start during sorting
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
    chk(got_n == exp_n, "R4", {tag, " edge count"}, got_n, exp_n);
  endtask

  task automatic fill_random();
    b_cnt = 1 + ($urandom % NT);
    for (int t = 0; t < NT; t++) begin
      int vid = $urandom % 16;
      b_base[t] = t * 8;
      b_len[t] = $urandom % 7;
      b_mts[t] = $urandom % 6;
      for (int e = 0; e < 8; e++) begin
        m_nbr[t*8+e]  = VW'($urandom % 16);
        m_root[t*8+e] = VW'(vid);
        m_ts[t*8+e]   = TSW'($urandom % 1000);
      end
    end
  endtask

  task automatic put(int a, int n, int r, int ts);
    m_nbr[a] = VW'(n); m_root[a] = VW'(r); m_ts[a] = TSW'(ts);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4711);
    ready_mode = 0;
    for (int a = 0; a < TBL; a++) put(a, 0, 0, 0);
    for (int t = 0; t < NT; t++) begin b_base[t] = 0; b_len[t] = 0; b_mts[t] = 0; end
    b_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !tbl_rd, "R1", "outputs after reset",
        int'({out_valid, done, tbl_rd}), 0);

    // Directed: tie on max timestamp, self loop, shared neighbors, empty target.
    b_cnt = 4;
    b_base[0] = 0;  b_len[0] = 3; b_mts[0] = 9;
    put(0, 3, 3, 9); put(1, 5, 3, 8); put(2, 7, 3, 6);
    b_base[1] = 8;  b_len[1] = 3; b_mts[1] = 4;
    put(8, 3, 5, 4); put(9, 7, 5, 3); put(10, 3, 5, 2);
    b_base[2] = 16; b_len[2] = 2; b_mts[2] = 9;
    put(16, 5, 7, 9); put(17, 11, 7, 1);
    b_base[3] = 24; b_len[3] = 0; b_mts[3] = 15;
    run_batch("directed", 0);
    chk(exp_n == 4, "R5", "directed reference size", exp_n, 4);
    chk(got_n >= 4 && e_nbr[3] == 3 && e_root[3] == 5, "R5",
        "self-looped vertex later emitted", int'(e_nbr[3]), 3);

    // Same batch again: visited cleared by start.
    ready_mode = 1;
    run_batch("repeat R6", 0);

    // Start pulse during a running batch.
    run_batch("poke R9", 1);

    // Empty batch.
    b_cnt = 0;
    run_batch("zero R10", 0);
    chk(exp_n == 0, "R10", "empty batch edges", got_n, 0);

    // Random batches with random backpressure.
    for (int r = 0; r < 40; r++) begin
      fill_random();
      ready_mode = r % 3 == 0 ? 0 : 1;
      run_batch("random", r % 5 == 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule